// File: doc/BRIEF.md
# Auto-Incrementing Work RAM Port

This block gives a processor byte-wide, streaming access to a 128 KiB work RAM through a single data register on its register bus. A 17-bit pointer, loaded one byte at a time through three pointer registers, selects the RAM byte. Every accepted access to the data register, whether a read or a write, performs exactly one RAM access at the pointer and then advances the pointer by one. This lets software fill or dump a buffer with a run of accesses to one register.

On the RAM side the block drives a synchronous request interface. The RAM answers a read one clock after the request, and the RAM address is a fixed 24-bit base of 0x7E0000 combined by OR with the pointer. The register bus offers an access strobe that may be held for several clocks. An edge detector turns each strobe into a single access pulse. Register reads complete with a one-cycle `bus_rvalid_o` pulse. While no read data is being presented, including while a RAM read is still in flight, the read-data output repeats the last value driven on the bus (`bus_open_i`).

The controller is a three-state machine. In `ST_IDLE` it accepts pulses. A data-register read takes the `IDLE_TO_WAIT` transition to `ST_RD_WAIT`. A read of a pointer register takes the `IDLE_TO_DONE` transition straight to `ST_RD_DONE`. Writes stay in `ST_IDLE`, which is the `IDLE_HOLD` transition. `ST_RD_WAIT` always takes `WAIT_TO_DONE` and captures the RAM byte on the way. `ST_RD_DONE` presents the result for one cycle and always takes `DONE_TO_IDLE`.

Top module: `seqram_port`

## Requirements
- R1: After reset the pointer is zero, so `mem_addr_o` reads 0x7E0000, and both `mem_req_o` and `bus_rvalid_o` are low.
- R2: Register select codes on `bus_sel_i` are 0 = data, 1 = pointer bits 7:0, 2 = pointer bits 15:8, 3 = pointer bit 16. A write to select 1 or 2 replaces only its byte of the pointer and leaves every other pointer bit unchanged.
- R3: A write to select 3 loads pointer bit 16 from data bit 0 and ignores data bits 7:1.
- R4: A data-register read issues one RAM request with `mem_we_o` low in the pulse cycle. The RAM byte appears on `bus_rdata_o`, with `bus_rvalid_o` high, two cycles after the pulse cycle. The pointer is one higher from the cycle after the pulse.
- R5: A data-register write issues one RAM request in the pulse cycle, with `mem_we_o` high and `mem_wdata_o` equal to the written byte. The pointer is one higher from the next cycle, and no `bus_rvalid_o` follows.
- R6: While a RAM read is pending (the cycle after the pulse), `bus_rvalid_o` is low and `bus_rdata_o` follows `bus_open_i`.
- R7: The pointer wraps from 0x1FFFF to 0x00000 when it advances.
- R8: A strobe held high for several clocks is one access: one RAM request and one pointer increment.
- R9: The pointer registers are write-only. Reading select 1, 2 or 3 makes no RAM request, leaves the pointer unchanged, and returns with `bus_rvalid_o` one cycle later the `bus_open_i` value of the pulse cycle.
- R10: A strobe pulse that arrives while a read is still in `ST_RD_WAIT` or `ST_RD_DONE` is dropped: no RAM request and no pointer change.
- R11: `mem_addr_o` always equals 0x7E0000 OR the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_i | input | 1 | Register access strobe (may be held) |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_sel_i | input | 2 | Register select (0 data, 1/2/3 pointer bytes) |
| bus_wdata_i | input | 8 | Write data |
| bus_open_i | input | 8 | Last value driven on the processor bus |
| bus_rdata_o | output | 8 | Read data, or the open-bus value when not valid |
| bus_rvalid_o | output | 1 | Read result valid, one cycle |
| mem_req_o | output | 1 | RAM access request |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | 24 | RAM byte address (base OR pointer) |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, valid one cycle after a read request |

## Verification
The bench sweeps every byte value through each pointer register. A design that merged the registers wrongly would corrupt neighbouring bits, and one that kept high bits from select 3 would move the address outside 128 KiB. Runs of writes and read-backs cross the 0xFFFF and 0x1FFFF boundaries, which catches a missing carry into bit 16 or a pointer that saturates instead of wrapping. Held strobes, and pulses during an outstanding read, expose a design that increments per cycle or lets a second access slip in. Pointer-register reads and the pending read cycle are checked against the open-bus input, which would catch a design that returns stale RAM data or the pointer itself.

// File: rtl/seqram_pkg.sv
package seqram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_RD_DONE = 2'd2
    } ctrl_state_e;

    typedef enum logic [1:0] {
        RG_DATA    = 2'd0,
        RG_PTR_LO  = 2'd1,
        RG_PTR_MID = 2'd2,
        RG_PTR_HI  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/seqram_strobe.sv
// Turns a possibly held access strobe into a one-cycle pulse (R8).
module seqram_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_i;
    end

    assign pulse_o = req_i & ~req_q;
endmodule

// File: rtl/seqram_ptr.sv
// Byte-loadable pointer with wrapping increment (R2, R3, R7).
module seqram_ptr #(
    parameter int PTR_W = 17,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo_i,
    input  logic             ld_mid_i,
    input  logic             ld_hi_i,
    input  logic             inc_i,
    input  logic [DW-1:0]    din_i,
    output logic [PTR_W-1:0] ptr_o
);
    localparam int HI_W = PTR_W - 2 * DW;

    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ld_lo_i) begin
            ptr_q[DW-1:0] <= din_i;
        end else if (ld_mid_i) begin
            ptr_q[2*DW-1:DW] <= din_i;
        end else if (ld_hi_i) begin
            ptr_q[PTR_W-1:2*DW] <= din_i[HI_W-1:0];
        end else if (inc_i) begin
            ptr_q <= ptr_q + PTR_W'(1);
        end
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/seqram_ctrl.sv
// Access controller: decodes pulses, issues RAM requests, sequences reads.
module seqram_ctrl
    import seqram_pkg::*;
#(
    parameter int              PTR_W  = 17,
    parameter int              ADDR_W = 24,
    parameter int              DW     = 8,
    parameter logic [23:0]     BASE   = 24'h7E0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    input  logic              we_i,
    input  logic [1:0]        sel_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [DW-1:0]     open_i,
    input  logic [DW-1:0]     mem_rdata_i,
    input  logic [PTR_W-1:0]  ptr_i,
    output logic              ld_lo_o,
    output logic              ld_mid_o,
    output logic              ld_hi_o,
    output logic              inc_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    output logic [DW-1:0]     rdata_o,
    output logic              rvalid_o
);
    ctrl_state_e state_q, state_d;
    reg_sel_e    sel;
    logic        accept;
    logic [DW-1:0] data_q;

    assign sel    = reg_sel_e'(sel_i);
    assign accept = pulse_i && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !we_i) begin
                    state_d = (sel == RG_DATA) ? ST_RD_WAIT : ST_RD_DONE;
                end
            end
            ST_RD_WAIT: state_d = ST_RD_DONE;
            ST_RD_DONE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // read result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept && !we_i) begin
            data_q <= open_i;
        end else if (state_q == ST_RD_WAIT) begin
            data_q <= mem_rdata_i;
        end
    end

    // outputs
    always_comb begin
        ld_lo_o     = 1'b0;
        ld_mid_o    = 1'b0;
        ld_hi_o     = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        if (accept) begin
            unique case (sel)
                RG_DATA: begin
                    mem_req_o = 1'b1;
                    mem_we_o  = we_i;
                end
                RG_PTR_LO:  ld_lo_o  = we_i;
                RG_PTR_MID: ld_mid_o = we_i;
                RG_PTR_HI:  ld_hi_o  = we_i;
                default: ;
            endcase
        end
        inc_o       = mem_req_o;
        mem_addr_o  = BASE[ADDR_W-1:0] | ADDR_W'(ptr_i);
        mem_wdata_o = wdata_i;
        rvalid_o    = (state_q == ST_RD_DONE);
        rdata_o     = rvalid_o ? data_q : open_i;
    end
endmodule

// File: rtl/seqram_port.sv
// Top: auto-incrementing byte window onto work RAM.
module seqram_port #(
    parameter int          PTR_W  = 17,
    parameter int          ADDR_W = 24,
    parameter int          DW     = 8,
    parameter logic [23:0] BASE   = 24'h7E0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [1:0]        bus_sel_i,
    input  logic [DW-1:0]     bus_wdata_i,
    input  logic [DW-1:0]     bus_open_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    input  logic [DW-1:0]     mem_rdata_i
);
    logic             pulse;
    logic             ld_lo, ld_mid, ld_hi, inc;
    logic [PTR_W-1:0] ptr;

    seqram_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (bus_req_i),
        .pulse_o (pulse)
    );

    seqram_ptr #(.PTR_W(PTR_W), .DW(DW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_lo_i  (ld_lo),
        .ld_mid_i (ld_mid),
        .ld_hi_i  (ld_hi),
        .inc_i    (inc),
        .din_i    (bus_wdata_i),
        .ptr_o    (ptr)
    );

    seqram_ctrl #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .DW(DW), .BASE(BASE)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_i     (pulse),
        .we_i        (bus_we_i),
        .sel_i       (bus_sel_i),
        .wdata_i     (bus_wdata_i),
        .open_i      (bus_open_i),
        .mem_rdata_i (mem_rdata_i),
        .ptr_i       (ptr),
        .ld_lo_o     (ld_lo),
        .ld_mid_o    (ld_mid),
        .ld_hi_o     (ld_hi),
        .inc_o       (inc),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .rdata_o     (bus_rdata_o),
        .rvalid_o    (bus_rvalid_o)
    );
endmodule

// File: rtl/seqram_port_chk.sv
module seqram_port_chk #(
    parameter int PTR_W  = 17,
    parameter int ADDR_W = 24,
    parameter int DW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req_i,
    input logic [DW-1:0]     bus_open_i,
    input logic [DW-1:0]     bus_rdata_o,
    input logic              bus_rvalid_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o
);
    // R8: a request only in the first cycle of a strobe
    p_single_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (bus_req_i && !$past(bus_req_i)));

    // R4: read result two cycles after the request
    p_rd_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |=> (!bus_rvalid_o ##1 bus_rvalid_o));

    // R5, R7: pointer advances by one (wrapping) after each RAM access
    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> (mem_addr_o[PTR_W-1:0] ==
                       PTR_W'($past(mem_addr_o[PTR_W-1:0]) + 1'b1)));

    // R5: writes produce no read result
    p_wr_no_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |=> !bus_rvalid_o);

    // R10: no request while a read is outstanding
    p_busy_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |=> !mem_req_o);

    // R10: pointer frozen into the result cycle
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid_o |-> $stable(mem_addr_o));

    // R6: open-bus value whenever no result is presented
    p_open_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid_o |-> (bus_rdata_o == bus_open_i));

    // R9: result valid lasts one cycle
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid_o |=> !bus_rvalid_o);
endmodule

bind seqram_port seqram_port_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_i    (bus_req_i),
    .bus_open_i   (bus_open_i),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o)
);

// File: tb/test_seqram_port.sv
`timescale 1ns/1ps
module test_seqram_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_open = 8'h5C;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'd0;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [16:0] mptr = 17'd0;
    logic [7:0]  ram   [int];
    logic [7:0]  shadow[int];

    always #10 clk = ~clk;

    seqram_port i_seqram_port (
        .clk(clk), .rst_n(rst_n),
        .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_sel_i(bus_sel),
        .bus_wdata_i(bus_wdata), .bus_open_i(bus_open),
        .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ (a[16] ? 8'hA5 : 8'h3C);
    endfunction

    function automatic logic [7:0] exp_byte(input logic [16:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : pat(a);
    endfunction

    // RAM model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) ram[int'(mem_addr[16:0])] = mem_wdata;
            else mem_rdata <= ram.exists(int'(mem_addr[16:0])) ?
                              ram[int'(mem_addr[16:0])] : pat(mem_addr[16:0]);
        end
    end

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_ptr(input string tag);
        chk_eq(tag, 64'(mem_addr), 64'(24'h7E0000 | 24'(mptr)));
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic ptr_set(input logic [16:0] p);
        reg_wr(2'd1, p[7:0]);
        reg_wr(2'd2, p[15:8]);
        reg_wr(2'd3, {7'd0, p[16]});
        mptr = p;
    endtask

    task automatic data_wr(input logic [7:0] d, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_sel = 2'd0; bus_wdata = d;
        #1;
        chk_eq({tag, " R5 request"}, {mem_req, mem_we, mem_addr, mem_wdata},
               {1'b1, 1'b1, 24'h7E0000 | 24'(mptr), d});
        shadow[int'(mptr)] = d;
        @(negedge clk);
        bus_req = 1'b0;
        mptr = mptr + 17'd1;
        chk_ptr({tag, " R5 advance"});
        chk_eq({tag, " R5 no valid"}, 64'(bus_rvalid), 64'd0);
    endtask

    task automatic data_rd(input string tag);
        logic [7:0] e;
        e = exp_byte(mptr);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_sel = 2'd0;
        #1;
        chk_eq({tag, " R4 request"}, {mem_req, mem_we, mem_addr},
               {1'b1, 1'b0, 24'h7E0000 | 24'(mptr)});
        @(negedge clk);
        bus_req = 1'b0;
        bus_open = bus_open + 8'h3B;
        #1;
        chk_eq({tag, " R6 pending open bus"}, {bus_rvalid, bus_rdata}, {1'b0, bus_open});
        mptr = mptr + 17'd1;
        chk_ptr({tag, " R4 advance"});
        @(negedge clk);
        chk_eq({tag, " R4 data"}, {bus_rvalid, bus_rdata}, {1'b1, e});
        @(negedge clk);
        chk_eq({tag, " R4 valid ends"}, 64'(bus_rvalid), 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int cnt;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 reset outputs", {mem_req, bus_rvalid, mem_addr}, {1'b0, 1'b0, 24'h7E0000});

        // R2 low-byte sweep with other bits set
        ptr_set(17'h1A5C3);
        for (int i = 0; i < 256; i++) begin
            reg_wr(2'd1, 8'(i));
            mptr[7:0] = 8'(i);
            chk_ptr("R2 low byte load");
        end
        // R2 middle-byte sweep
        for (int i = 0; i < 256; i++) begin
            reg_wr(2'd2, 8'(255 - i));
            mptr[15:8] = 8'(255 - i);
            chk_ptr("R2 middle byte load");
        end
        // R3 high register: only bit 0 kept
        for (int i = 0; i < 256; i++) begin
            reg_wr(2'd3, 8'(i));
            mptr[16] = i[0];
            chk_ptr("R3 high bit load");
        end
        // R11 address always base OR pointer
        ptr_set(17'h00000);
        chk_eq("R11 base at zero", 64'(mem_addr), 64'h7E0000);

        // R5 write run across 0xFFFF carry
        ptr_set(17'h0FF80);
        for (int i = 0; i < 256; i++) data_wr(8'((i * 7 + 3) & 255), "stream wr");
        // R4 read back
        ptr_set(17'h0FF80);
        for (int i = 0; i < 256; i++) data_rd("stream rd");
        // R4 unwritten region
        ptr_set(17'h1ABCD);
        for (int i = 0; i < 16; i++) data_rd("pattern rd");

        // R7 wrap on write and read
        ptr_set(17'h1FFFF);
        data_wr(8'hC7, "wrap wr");
        chk_eq("R7 wrap after write", 64'(mem_addr), 64'h7E0000);
        ptr_set(17'h1FFFF);
        data_rd("wrap rd");
        chk_eq("R7 wrap after read", 64'(mem_addr), 64'h7E0000);

        // R8 held write strobe
        ptr_set(17'h01234);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_sel = 2'd0; bus_wdata = 8'h9E;
        cnt = 0;
        for (int k = 0; k < 5; k++) begin
            #1; if (mem_req) cnt++;
            @(negedge clk);
        end
        bus_req = 1'b0;
        shadow[int'(mptr)] = 8'h9E;
        mptr = mptr + 17'd1;
        chk_eq("R8 one request for held write", 64'(cnt), 64'd1);
        chk_ptr("R8 one increment for held write");
        // R8 held read strobe
        ptr_set(17'h01234);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_sel = 2'd0;
        cnt = 0;
        for (int k = 0; k < 6; k++) begin
            #1; if (bus_rvalid) begin cnt++; v = bus_rdata; end
            @(negedge clk);
        end
        bus_req = 1'b0;
        mptr = mptr + 17'd1;
        chk_eq("R8 one result for held read", 64'(cnt), 64'd1);
        chk_eq("R8 held read data", 64'(v), 64'h9E);
        chk_ptr("R8 one increment for held read");

        // R9 pointer registers read as open bus
        ptr_set(17'h15A5A);
        for (int s = 1; s < 4; s++) begin
            @(negedge clk);
            bus_req = 1'b1; bus_we = 1'b0; bus_sel = 2'(s);
            bus_open = 8'(8'h40 + s * 17);
            v = bus_open;
            #1;
            chk_eq("R9 no request on pointer read", 64'(mem_req), 64'd0);
            @(negedge clk);
            bus_req = 1'b0;
            bus_open = 8'hEE;
            #1;
            chk_eq("R9 open-bus result", {bus_rvalid, bus_rdata}, {1'b1, v});
            @(negedge clk);
            chk_ptr("R9 pointer unchanged");
        end

        // R10 pulses during an outstanding read are dropped
        for (int t = 0; t < 2; t++) begin
            ptr_set(17'h00400);
            @(negedge clk);
            bus_req = 1'b1; bus_we = 1'b0; bus_sel = 2'd0;
            @(negedge clk);
            bus_req = 1'b0;
            @(negedge clk);
            bus_req = 1'b1; bus_we = 1'b1; bus_sel = 2'(t); bus_wdata = 8'h77;
            #1;
            chk_eq("R10 no request while busy", 64'(mem_req), 64'd0);
            @(negedge clk);
            bus_req = 1'b0;
            @(negedge clk);
            mptr = 17'h00401;
            chk_ptr("R10 pointer unaffected by busy pulse");
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule